// File: doc/BRIEF.md
# Audio Clock Ratio Generator

This block derives a serial-audio bit clock and a frame (word-select) clock from a master clock. Each cycle of `clk` is one master-clock period. The bit clock is the master clock divided by 2 or 4. The frame clock is the bit clock divided by 32, 64 or 128. Both clocks come out as registered 50% duty square waves. Each also has a one-cycle strobe that marks the start of its period, so logic in the master-clock domain can shift sample data without a second clock domain.

The divisors come from one of two sources. They can be set directly. In automatic mode they are chosen from the ratio of master clock to sample rate, using two fixed thresholds. In automatic mode the frame divisor never drops below 64, because a frame must carry two 32-bit slots.

A new divisor setting is taken only where one frame ends, so a frame is never cut short. Pulling the enable low forces the outputs idle and clears the counters. The next enable starts a clean frame.

Top module: `audio_ratio_clkgen`

## Requirements
- R1: While `en` is sampled low, `sclk_o`, `fclk_o`, `bit_tick` and `frame_tick` are all 0 from the following cycle on.
- R2: A bit period lasts 2 master cycles when `bit_div_sel` is 0 and 4 when it is 1. In each bit period `sclk_o` is low for the first half and high for the second half, and `bit_tick` is high only in its first cycle.
- R3: A frame lasts 32 bit periods for `frame_div_sel` code 0, 64 for code 1 and 128 for codes 2 and 3. In each frame `fclk_o` is low for the first half and high for the second half.
- R4: With `auto_mode` at 1 and `ratio` above HI_LIMIT (default 384), the bit divisor is 4 and the frame divisor is 128, whatever the manual selects hold.
- R5: With `auto_mode` at 1 and `ratio` below LO_LIMIT (default 192), the divisors are 2 and 64. For `ratio` from LO_LIMIT to HI_LIMIT inclusive they are 4 and 64.
- R6: The divisor selection is sampled only when a frame starts: on the clock edge that ends the previous frame, or on the start after enable. A change applied at any point inside a frame, including its last cycle, leaves that frame's length unchanged and governs the next frame.
- R7: In the first cycle after `en` is sampled high from idle, `frame_tick` and `bit_tick` are both 1 and a complete frame follows.
- R8: `frame_tick` is high only in a cycle where `bit_tick` is high, and it is high exactly once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces idle and clears the counters |
| auto_mode | input | 1 | 1: divisors derived from `ratio`; 0: manual selects |
| ratio | input | RATIO_W | Master-clock to sample-rate ratio |
| bit_div_sel | input | 1 | Manual bit divisor: 0 gives 2, 1 gives 4 |
| frame_div_sel | input | 2 | Manual frame divisor: 0 gives 32, 1 gives 64, 2 and 3 give 128 |
| sclk_o | output | 1 | Bit clock, 50% duty |
| fclk_o | output | 1 | Frame clock, 50% duty, low in the first half of a frame |
| bit_tick | output | 1 | One-cycle strobe at the start of each bit period |
| frame_tick | output | 1 | One-cycle strobe at the start of each frame |

## Verification
The counter wrap at the end of a frame and the reload of the divisor selection happen on the same clock edge, so the two can collide. The bench provokes this collision by changing the manual selects exactly in the final master cycle of a frame. It also makes a change a few cycles into a frame, for comparison. In both cases it judges the result by counting master cycles and bit strobes between successive frame strobes: the frame in progress must keep its old length and the next frame must take the new one. The disable path is tested in a similar way. The bench drops `en` in the middle of a frame and re-enables it a cycle later, then checks that the idle cycle is clean and that the frame which follows is complete.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int MAX_BIT_DIV   = 4;
    localparam int MAX_FRAME_DIV = 128;
    localparam int MCNT_W        = $clog2(MAX_BIT_DIV);
    localparam int BCNT_W        = $clog2(MAX_FRAME_DIV);

    // bit4: bit divisor is 4 (else 2); fcode: 0 -> 32, 1 -> 64, 2 -> 128
    typedef struct packed {
        logic       bit4;
        logic [1:0] fcode;
    } div_cfg_t;

    function automatic logic [MCNT_W-1:0] bit_last(input logic bit4);
        return bit4 ? MCNT_W'(MAX_BIT_DIV - 1) : MCNT_W'(MAX_BIT_DIV / 2 - 1);
    endfunction

    function automatic logic [MCNT_W-1:0] bit_half(input logic bit4);
        return bit4 ? MCNT_W'(MAX_BIT_DIV / 2) : MCNT_W'(MAX_BIT_DIV / 4);
    endfunction

    function automatic logic [BCNT_W-1:0] frame_last(input logic [1:0] fcode);
        case (fcode)
            2'd0:    return BCNT_W'(MAX_FRAME_DIV / 4 - 1);
            2'd1:    return BCNT_W'(MAX_FRAME_DIV / 2 - 1);
            default: return BCNT_W'(MAX_FRAME_DIV - 1);
        endcase
    endfunction

    function automatic logic [BCNT_W-1:0] frame_half(input logic [1:0] fcode);
        case (fcode)
            2'd0:    return BCNT_W'(MAX_FRAME_DIV / 8);
            2'd1:    return BCNT_W'(MAX_FRAME_DIV / 4);
            default: return BCNT_W'(MAX_FRAME_DIV / 2);
        endcase
    endfunction

endpackage

// File: rtl/acr_ratio_pick.sv
module acr_ratio_pick
    import acr_pkg::*;
#(
    parameter int                  RATIO_W  = 12,
    parameter logic [RATIO_W-1:0]  HI_LIMIT = RATIO_W'(384),
    parameter logic [RATIO_W-1:0]  LO_LIMIT = RATIO_W'(192)
) (
    input  logic               auto_mode,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               man_bit4,
    input  logic [1:0]         man_fcode,
    output div_cfg_t           req_o
);

    always_comb begin
        if (auto_mode) begin
            if (ratio > HI_LIMIT) begin
                req_o.bit4  = 1'b1;
                req_o.fcode = 2'd2;
            end else if (ratio < LO_LIMIT) begin
                req_o.bit4  = 1'b0;
                req_o.fcode = 2'd1;
            end else begin
                req_o.bit4  = 1'b1;
                req_o.fcode = 2'd1;
            end
        end else begin
            req_o.bit4  = man_bit4;
            req_o.fcode = (man_fcode == 2'd3) ? 2'd2 : man_fcode;
        end
    end

endmodule

// File: rtl/acr_div_core.sv
module acr_div_core
    import acr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  div_cfg_t req_i,
    output logic     sclk_o,
    output logic     fclk_o,
    output logic     btick_o,
    output logic     ftick_o
);

    typedef struct packed {
        logic              run;
        logic [MCNT_W-1:0] mcnt;
        logic [BCNT_W-1:0] bcnt;
        div_cfg_t          cfg;
        logic              sclk;
        logic              fclk;
        logic              btick;
        logic              ftick;
    } core_t;

    core_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d     = '0;
            state_d.cfg = req_i;
        end else if (!state_q.run) begin
            state_d.run  = 1'b1;
            state_d.mcnt = '0;
            state_d.bcnt = '0;
            state_d.cfg  = req_i;
        end else if (state_q.mcnt == bit_last(state_q.cfg.bit4)) begin
            state_d.mcnt = '0;
            if (state_q.bcnt == frame_last(state_q.cfg.fcode)) begin
                state_d.bcnt = '0;
                state_d.cfg  = req_i;
            end else begin
                state_d.bcnt = state_q.bcnt + 1'b1;
            end
        end else begin
            state_d.mcnt = state_q.mcnt + 1'b1;
        end
        state_d.btick = state_d.run && (state_d.mcnt == '0);
        state_d.ftick = state_d.btick && (state_d.bcnt == '0);
        state_d.sclk  = state_d.run && (state_d.mcnt >= bit_half(state_d.cfg.bit4));
        state_d.fclk  = state_d.run && (state_d.bcnt >= frame_half(state_d.cfg.fcode));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sclk_o  = state_q.sclk;
    assign fclk_o  = state_q.fclk;
    assign btick_o = state_q.btick;
    assign ftick_o = state_q.ftick;

endmodule

// File: rtl/audio_ratio_clkgen.sv
module audio_ratio_clkgen
    import acr_pkg::*;
#(
    parameter int                  RATIO_W  = 12,
    parameter logic [RATIO_W-1:0]  HI_LIMIT = RATIO_W'(384),
    parameter logic [RATIO_W-1:0]  LO_LIMIT = RATIO_W'(192)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               auto_mode,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               bit_div_sel,
    input  logic [1:0]         frame_div_sel,
    output logic               sclk_o,
    output logic               fclk_o,
    output logic               bit_tick,
    output logic               frame_tick
);

    div_cfg_t req_cfg;

    acr_ratio_pick #(
        .RATIO_W  (RATIO_W),
        .HI_LIMIT (HI_LIMIT),
        .LO_LIMIT (LO_LIMIT)
    ) i_pick (
        .auto_mode (auto_mode),
        .ratio     (ratio),
        .man_bit4  (bit_div_sel),
        .man_fcode (frame_div_sel),
        .req_o     (req_cfg)
    );

    acr_div_core i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .req_i   (req_cfg),
        .sclk_o  (sclk_o),
        .fclk_o  (fclk_o),
        .btick_o (bit_tick),
        .ftick_o (frame_tick)
    );

endmodule

// File: rtl/audio_ratio_clkgen_chk.sv
module audio_ratio_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sclk_o,
    input logic fclk_o,
    input logic bit_tick,
    input logic frame_tick
);

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sclk_o && !fclk_o && !bit_tick && !frame_tick)); // R1

    AST_BIT_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick); // R2

    AST_SCLK_LOW_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> !sclk_o); // R2

    AST_FCLK_LOW_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> !fclk_o); // R3

    AST_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> (frame_tick && bit_tick)); // R7

    AST_FRAME_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> bit_tick); // R8

endmodule

bind audio_ratio_clkgen audio_ratio_clkgen_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .sclk_o     (sclk_o),
    .fclk_o     (fclk_o),
    .bit_tick   (bit_tick),
    .frame_tick (frame_tick)
);

// File: tb/test_audio_ratio_clkgen.sv
`timescale 1ns/1ps
module test_audio_ratio_clkgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        auto_mode = 1'b0;
    logic [11:0] ratio = '0;
    logic        bit_div_sel = 1'b0;
    logic [1:0]  frame_div_sel = 2'd0;
    logic        sclk_o, fclk_o, bit_tick, frame_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    audio_ratio_clkgen i_audio_ratio_clkgen (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .auto_mode     (auto_mode),
        .ratio         (ratio),
        .bit_div_sel   (bit_div_sel),
        .frame_div_sel (frame_div_sel),
        .sclk_o        (sclk_o),
        .fclk_o        (fclk_o),
        .bit_tick      (bit_tick),
        .frame_tick    (frame_tick)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int bdiv_of(input logic b);
        return b ? 4 : 2;
    endfunction

    function automatic int fdiv_of(input logic [1:0] f);
        return (f == 2'd0) ? 32 : (f == 2'd1) ? 64 : 128;
    endfunction

    task automatic wait_frame();
        do @(negedge clk); while (!frame_tick);
    endtask

    // Called at a negedge showing frame_tick; returns at the next one.
    task automatic measure(input int at, input logic nb4, input logic [1:0] nfc,
                           output int n, output int nb, output int hi,
                           output int fhi, output int f0);
        n = 0; nb = 0; hi = 0; fhi = 0;
        f0 = int'(fclk_o);
        do begin
            if (bit_tick) nb++;
            if (sclk_o)   hi++;
            if (fclk_o)   fhi++;
            if (n == at) begin
                bit_div_sel   = nb4;
                frame_div_sel = nfc;
            end
            n++;
            @(negedge clk);
        end while (!frame_tick && n < 4000);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset sclk", int'(sclk_o), 0);
        check("R1 reset fclk", int'(fclk_o), 0);
        check("R1 reset ticks", int'(bit_tick | frame_tick), 0);
    endtask

    task automatic t_manual(input logic b, input logic [1:0] f);
        int n, nb, hi, fhi, f0, exp;
        bit_div_sel = b; frame_div_sel = f; auto_mode = 1'b0;
        wait_frame();
        measure(-1, b, f, n, nb, hi, fhi, f0);
        exp = bdiv_of(b) * fdiv_of(f);
        check("R3 frame length", n, exp);
        check("R2 bit ticks per frame", nb, fdiv_of(f));
        check("R2 sclk high half", hi, exp / 2);
        check("R3 fclk high half", fhi, exp / 2);
        check("R3 fclk low at frame start", f0, 0);
    endtask

    task automatic t_auto(input int r, input int eb, input int ef, input string req);
        int n, nb, hi, fhi, f0;
        auto_mode = 1'b1; ratio = 12'(r);
        bit_div_sel = ~bit_div_sel; frame_div_sel = 2'd0;
        wait_frame();
        measure(-1, bit_div_sel, frame_div_sel, n, nb, hi, fhi, f0);
        check({req, " auto frame length"}, n, eb * ef);
        check({req, " auto bits per frame"}, nb, ef);
        auto_mode = 1'b0;
    endtask

    task automatic t_change();
        int n, nb, hi, fhi, f0;
        bit_div_sel = 1'b0; frame_div_sel = 2'd1;
        wait_frame();
        wait_frame();
        measure(10, 1'b1, 2'd2, n, nb, hi, fhi, f0);
        check("R6 mid-frame change keeps frame", n, 128);
        measure(-1, 1'b1, 2'd2, n, nb, hi, fhi, f0);
        check("R6 next frame takes change", n, 512);
        measure(511, 1'b0, 2'd0, n, nb, hi, fhi, f0);
        check("R6 last-cycle change keeps frame", n, 512);
        measure(-1, 1'b0, 2'd0, n, nb, hi, fhi, f0);
        check("R6 last-cycle change next frame", n, 64);
        check("R8 one frame tick per 32 bits", nb, 32);
    endtask

    task automatic t_restart();
        int n, nb, hi, fhi, f0;
        bit_div_sel = 1'b1; frame_div_sel = 2'd0;
        wait_frame();
        repeat (37) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R1 idle after disable", int'(sclk_o | fclk_o | bit_tick | frame_tick), 0);
        en = 1'b1;
        @(negedge clk);
        check("R7 frame tick on start", int'(frame_tick), 1);
        check("R7 bit tick on start", int'(bit_tick), 1);
        measure(-1, 1'b1, 2'd0, n, nb, hi, fhi, f0);
        check("R7 full frame after restart", n, 128);
        check("R8 frame tick with bit tick count", nb, 32);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        en = 1'b1;
        t_manual(1'b0, 2'd0);
        t_manual(1'b1, 2'd0);
        t_manual(1'b0, 2'd2);
        t_manual(1'b1, 2'd1);
        t_manual(1'b0, 2'd3);
        t_auto(385, 4, 128, "R4");
        t_auto(384, 4, 64, "R5");
        t_auto(192, 4, 64, "R5");
        t_auto(191, 2, 64, "R5");
        t_change();
        t_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule